// File: doc/BRIEF.md
# Sequential Signed Shift-Add Multiplier

This unit multiplies two signed 32-bit two's-complement numbers over several clock cycles and returns the low 32 bits of the product. It reuses one adder/subtractor on every cycle. It reads the multiplier from its most significant bit down to bit 0. The top bit counts as minus two to the thirty-first power, so that step subtracts the multiplicand. Every lower bit counts with its normal positive weight, so that step adds the shifted multiplicand. Because of this, negative operands need no absolute-value pass before the loop and no negation after it.

A client pulses `start` while the unit is idle. The unit captures both operands on that edge and raises `busy`. After one sign step and thirty-one shift-add steps, `product` holds the wrapped result. `done` goes high for one cycle at the same moment as `busy` falls. The result then stays on `product` until the next accepted start.

Top module: `signed_mul_seq`

## Requirements
- R1: While reset is asserted and directly after it is released, `busy` is 0, `done` is 0 and `product` is 0.
- R2: A `start` sampled high while `busy` is low is accepted. It captures `multiplicand` and `multiplier` on that edge, and `busy` reads 1 in the following cycle.
- R3: Counting the accepting edge as edge 0, `busy` stays 1 and `done` stays 0 after edges 1 to 31. After edge 32, `done` is 1 and `busy` is 0. After edge 33, `done` is 0 again.
- R4: When `done` is 1, `product` equals the low 32 bits of the signed product of the captured operands, and any overflow wraps silently.
- R5: Bit 31 of the multiplier counts as -2^31, so negative multipliers, including -2^31 and -1, produce correct wrapped results.
- R6: A `start` sampled while `busy` is 1 is ignored. It changes neither the result nor the cycle in which `done` appears.
- R7: While the unit is idle and no start is accepted, `product` keeps its last value.
- R8: Changes on `multiplicand` or `multiplier` after the accepting edge have no effect on the result in progress.
- R9: A zero multiplier yields a product of 0 for any multiplicand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| start | input | 1 | Request to begin a multiply; accepted only when idle |
| multiplicand | input | 32 | Signed multiplicand, captured on an accepted start |
| multiplier | input | 32 | Signed multiplier, captured on an accepted start |
| busy | output | 1 | High while a multiply is in progress |
| done | output | 1 | One-cycle pulse marking a valid result |
| product | output | 32 | Low 32 bits of the signed product |

## Verification
The checker assumes that `start` is a level sampled at each rising edge, and that `rst_n` is released in step with the clock, so the edge-count window starts cleanly from the accepting edge. The assertions also take it that pulses of `start` can arrive in any cycle. For that reason they make no assumption that `start` is quiet while `busy` is high. The bench drives every input on the falling edge. It deliberately sends a start pulse and changes the operands in the middle of a multiply, so that the ignored cases are exercised inside the assumed input space.

// File: rtl/smul_pkg.sv
package smul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SIGN = 2'd1,
    ST_STEP = 2'd2
  } smul_state_e;
endpackage

// File: rtl/smul_addsub.sv
// Shared adder/subtractor: y = en ? (sub ? a - b : a + b) : a
module smul_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         en,
  output logic [W-1:0] y
);
  logic [W-1:0] b_eff;
  logic [W-1:0] sum;

  always_comb begin
    b_eff = b ^ {W{sub}};
    sum   = a + b_eff + {{(W-1){1'b0}}, sub};
    y     = en ? sum : a;
  end
endmodule

// File: rtl/smul_stepcnt.sv
// Counts the positive-weight steps that follow the sign step.
module smul_stepcnt #(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic dec,
  output logic last
);
  localparam int CW = $clog2(W) + 1;
  localparam logic [CW-1:0] STEPS = CW'(W - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_n;
  logic          cnt_en;

  always_comb begin
    cnt_en = load | dec;
    cnt_n  = load ? STEPS : (cnt_q - CW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_n;
    end
  end

  assign last = (cnt_q == CW'(1));
endmodule

// File: rtl/smul_ctrl.sv
module smul_ctrl
  import smul_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        last,
  output smul_state_e state,
  output logic        accept,
  output logic        done
);
  smul_state_e state_n;
  logic        done_n;

  always_comb begin
    state_n = state;
    accept  = 1'b0;
    done_n  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          accept  = 1'b1;
          state_n = ST_SIGN;
        end
      end
      ST_SIGN: state_n = ST_STEP;
      ST_STEP: begin
        if (last) begin
          state_n = ST_IDLE;
          done_n  = 1'b1;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= state_n;
      done  <= done_n;
    end
  end
endmodule

// File: rtl/signed_mul_seq.sv
module signed_mul_seq
  import smul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] multiplicand,
  input  logic [W-1:0] multiplier,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] product
);
  smul_state_e state;
  logic        accept;
  logic        last;
  logic        in_sign;
  logic        in_step;
  logic        active;

  logic [W-1:0] mcand_q, mcand_n;
  logic [W-1:0] mplr_q,  mplr_n;
  logic [W-1:0] prod_q,  prod_n;
  logic         op_en;
  logic [W-1:0] alu_a, alu_y;

  smul_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .last   (last),
    .state  (state),
    .accept (accept),
    .done   (done)
  );

  smul_stepcnt #(.W(W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (in_sign),
    .dec   (in_step),
    .last  (last)
  );

  // Sign step starts from zero and subtracts; later steps double and add.
  smul_addsub #(.W(W)) u_alu (
    .a   (alu_a),
    .b   (mcand_q),
    .sub (in_sign),
    .en  (mplr_q[W-1]),
    .y   (alu_y)
  );

  always_comb begin
    in_sign = (state == ST_SIGN);
    in_step = (state == ST_STEP);
    active  = in_sign | in_step;
    alu_a   = in_sign ? '0 : {prod_q[W-2:0], 1'b0};
    op_en   = accept | active;
    mcand_n = accept ? multiplicand : mcand_q;
    mplr_n  = accept ? multiplier   : {mplr_q[W-2:0], 1'b0};
    prod_n  = alu_y;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
      mplr_q  <= '0;
    end else if (op_en) begin
      mcand_q <= mcand_n;
      mplr_q  <= mplr_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
    end else if (active) begin
      prod_q <= prod_n;
    end
  end

  assign busy    = active;
  assign product = prod_q;
endmodule

// File: rtl/signed_mul_seq_checker.sv
module signed_mul_seq_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] product
);
  localparam int CYW = $clog2(W) + 2;

  logic [CYW-1:0] cyc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= '0;
    end else if (start && !busy) begin
      cyc_q <= '0;
    end else if (busy) begin
      cyc_q <= cyc_q + CYW'(1);
    end
  end

  a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r3_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cyc_q == CYW'(W)));

  a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(product));
endmodule

bind signed_mul_seq signed_mul_seq_checker #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .product (product)
);

// File: tb/signed_mul_seq_bench.sv
`timescale 1ns/1ps
module signed_mul_seq_bench;
  logic        clk;
  logic        rst_n;
  logic        start;
  logic [31:0] multiplicand;
  logic [31:0] multiplier;
  logic        busy;
  logic        done;
  logic [31:0] product;

  int n_chk;
  int n_err;

  signed_mul_seq u_signed_mul_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .multiplicand (multiplicand),
    .multiplier   (multiplier),
    .busy         (busy),
    .done         (done),
    .product      (product)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] ref_mul(input logic [31:0] a, input logic [31:0] b);
    longint p;
    p = longint'($signed(a)) * longint'($signed(b));
    return p[31:0];
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // mode 0: plain, 1: start pulse while busy (R6), 2: operand inputs change (R8)
  task automatic run_mul(input logic [31:0] a, input logic [31:0] b,
                         input int mode, input string req);
    logic [31:0] exp;
    bit          bad;
    exp = ref_mul(a, b);
    @(negedge clk);
    multiplicand = a;
    multiplier   = b;
    start        = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2", {31'd0, busy}, 32'd1);
    if (mode == 2) begin
      multiplicand = ~a;
      multiplier   = b ^ 32'h5a5a_a5a5;
    end
    bad = 1'b0;
    for (int k = 1; k <= 32; k++) begin
      if (mode == 1 && k == 10) begin
        start        = 1'b1;
        multiplicand = a + 32'd3;
        multiplier   = ~b;
      end
      if (mode == 1 && k == 11) start = 1'b0;
      @(negedge clk);
      if (k < 32 && (done || !busy)) bad = 1'b1;
    end
    check(!bad && done && !busy, (mode == 1) ? "R6" : "R3",
          {30'd0, busy, done}, 32'd1);
    check(product == exp, req, product, exp);
    @(negedge clk);
    check(!done, "R3", {31'd0, done}, 32'd0);
    multiplicand = 32'hdead_beef;
    multiplier   = 32'h1357_9bdf;
    repeat (3) @(negedge clk);
    check(product == exp && !busy, "R7", product, exp);
  endtask

  initial begin
    n_chk = 0;
    n_err = 0;
    void'($urandom(32'h0000_5eed));
    rst_n        = 1'b0;
    start        = 1'b0;
    multiplicand = '0;
    multiplier   = '0;
    repeat (3) @(negedge clk);
    check(!busy && !done && product == 32'd0, "R1",
          product | {30'd0, busy, done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && product == 32'd0, "R1",
          product | {30'd0, busy, done}, 32'd0);

    run_mul(32'd7, 32'd6, 0, "R4");
    run_mul(32'h7fff_ffff, 32'd2, 0, "R4");
    run_mul(32'hffff_fffb, 32'd3, 0, "R4");
    run_mul(32'h8000_0000, 32'hffff_ffff, 0, "R5");
    run_mul(32'hffff_ffff, 32'hffff_ffff, 0, "R5");
    run_mul(32'd5, 32'hffff_fffd, 0, "R5");
    run_mul(32'd1, 32'h8000_0000, 0, "R5");
    run_mul(32'h8000_0000, 32'h8000_0000, 0, "R5");
    run_mul(32'd12345, 32'd0, 0, "R9");
    run_mul(32'h8000_0000, 32'd0, 0, "R9");
    run_mul(32'd0, 32'hffff_fff9, 0, "R4");
    run_mul(32'h0001_e848, 32'h0001_e848, 0, "R4");
    run_mul(32'h1234_5678, 32'hfedc_ba98, 1, "R6");
    run_mul(32'hcafe_f00d, 32'h0000_0101, 2, "R8");
    for (int i = 0; i < 40; i++) begin
      run_mul($urandom, $urandom, 0, "R4");
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog R3 act=%h exp=%h", 32'd0, 32'd1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule